// File: doc/BRIEF.md
# Sampler Register Power-Up Loader

This block brings a sampling chip's internal shift registers into a known state after power-up. It drives the chip's 4-bit register-select bus, a serial data line and a serial shift clock. The chip's own reset line is never used, because one of its registers has no reset path.

A single start pulse runs a fixed sequence. First it loads an 8-bit configuration word. Next it loads an 8-bit write-shift word. Last it fills the long read-shift ring with zeros, with a single one as its final bit. That leaves exactly one marker at the entry position, which is cell 0 of the ring. The ring then returns to the same state after every full revolution of shift clocks.

The two 8-bit values come from input ports and are captured at the moment of start. When the sequence finishes, a one-cycle done pulse is issued. The chip itself sits outside this block.

Top module: `smp_reg_init_seq`

## Requirements
- R1: After reset: select bus at the idle code (default 4'b0000), shift clock low, serial data low, done low.
- R2: The configuration segment drives select code 4'b1100 and shifts exactly CFG_W bits of the captured configuration value, most significant bit first.
- R3: The write-shift segment drives select code 4'b1101 and shifts exactly WSR_W bits of the captured write-shift value, most significant bit first.
- R4: The read-shift segment drives select code 4'b1011 and shifts RSR_LEN bits: RSR_LEN-1 zeros, then one 1. Whatever the ring held before, it ends with only its entry bit set.
- R5: Segments run in the order configuration, write-shift, read-shift. Between two segments the select bus sits at the idle code for exactly one cycle.
- R6: Each bit takes three cycles: setup with the clock low, one cycle with the clock high, and hold with the clock low. The data is the same in all three cycles.
- R7: The select bus only changes while the shift clock is low. It never passes directly from one register code to another, and it is a register code whenever the clock is high.
- R8: done goes high for exactly one cycle, with the bus idle and the clock low. That cycle comes 3*(CFG_W+WSR_W+RSR_LEN)+3 clock cycles after the edge that samples start.
- R9: A start pulse seen while a sequence is running is ignored. It adds no segment and does not change the timing.
- R10: Changes on the value inputs after start has been sampled have no effect on the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when idle |
| cfg_val_i | input | CFG_W | Configuration register value |
| wsr_val_i | input | WSR_W | Write-shift register value |
| addr_o | output | AW | Chip register-select bus |
| sclk_o | output | 1 | Serial shift clock |
| sdata_o | output | 1 | Serial data, valid around each rising shift clock |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps the default 8-bit configuration and write-shift widths but shortens the read-shift ring to 32 cells. A full sequence then lasts 147 cycles instead of more than 3000. That lets several runs fit in a short test: the typical all-ones load, alternating and single-bit edge patterns, start pulses in the middle of a run, and value changes after start. The behavioural chip model's ring starts at all ones and is re-initialized on every run. This shows that the final single marker does not depend on the ring's earlier contents.

// File: rtl/smp_init_pkg.sv
package smp_init_pkg;
  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_CFG,
    SEG_GAP_A,
    SEG_WSR,
    SEG_GAP_B,
    SEG_RSR
  } seg_e;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_HIGH,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/smp_bit_phaser.sv
module smp_bit_phaser
  import smp_init_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic bit_end_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_SETUP;
    else if (!run_i) ph_q <= PH_SETUP;
    else begin
      unique case (ph_q)
        PH_SETUP: ph_q <= PH_HIGH;
        PH_HIGH:  ph_q <= PH_HOLD;
        default:  ph_q <= PH_SETUP;
      endcase
    end
  end

  assign sclk_o    = run_i && (ph_q == PH_HIGH);
  assign bit_end_o = run_i && (ph_q == PH_HOLD);

  // R6: a high clock is always followed by the hold phase
  p_clk_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> bit_end_o);
endmodule

// File: rtl/smp_seg_ctrl.sv
module smp_seg_ctrl
  import smp_init_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int WSR_W   = 8,
  parameter int RSR_LEN = 1024,
  parameter int CNT_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_end_i,
  output seg_e             seg_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             load_o,
  output logic             done_o
);
  seg_e             seg_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] last_idx;
  logic             done_q;

  always_comb begin
    unique case (seg_q)
      SEG_CFG: last_idx = CNT_W'(CFG_W - 1);
      SEG_WSR: last_idx = CNT_W'(WSR_W - 1);
      SEG_RSR: last_idx = CNT_W'(RSR_LEN - 1);
      default: last_idx = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (seg_q)
        SEG_IDLE: if (start_i) begin
          seg_q <= SEG_CFG;
          idx_q <= '0;
        end
        SEG_GAP_A: seg_q <= SEG_WSR;
        SEG_GAP_B: seg_q <= SEG_RSR;
        default: if (bit_end_i) begin
          if (idx_q == last_idx) begin
            idx_q <= '0;
            if (seg_q == SEG_CFG) seg_q <= SEG_GAP_A;
            else if (seg_q == SEG_WSR) seg_q <= SEG_GAP_B;
            else begin
              seg_q  <= SEG_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign seg_o  = seg_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign load_o = (seg_q == SEG_IDLE) && start_i;

  p_cfg_then_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_CFG) |=> (seg_q == SEG_CFG || seg_q == SEG_GAP_A));
  p_gap_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_GAP_B) |=> (seg_q == SEG_RSR));
  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_WSR && start_i) |=> (seg_q == SEG_WSR || seg_q == SEG_GAP_B));
endmodule

// File: rtl/smp_word_serializer.sv
module smp_word_serializer
  import smp_init_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int WSR_W   = 8,
  parameter int RSR_LEN = 1024,
  parameter int CNT_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_val_i,
  input  logic [WSR_W-1:0] wsr_val_i,
  input  seg_e             seg_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic             sdata_o
);
  logic [CFG_W-1:0] cfg_q, cfg_sh;
  logic [WSR_W-1:0] wsr_q, wsr_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '1;
      wsr_q <= '1;
    end else if (load_i) begin
      cfg_q <= cfg_val_i;
      wsr_q <= wsr_val_i;
    end
  end

  // msb first: shift the index-th bit up to the top
  assign cfg_sh = cfg_q << idx_i;
  assign wsr_sh = wsr_q << idx_i;

  always_comb begin
    unique case (seg_i)
      SEG_CFG: sdata_o = cfg_sh[CFG_W-1];
      SEG_WSR: sdata_o = wsr_sh[WSR_W-1];
      SEG_RSR: sdata_o = (idx_i == CNT_W'(RSR_LEN - 1));
      default: sdata_o = 1'b0;
    endcase
  end

  p_capture_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_i != SEG_IDLE) |=> ($stable(cfg_q) && $stable(wsr_q)));
endmodule

// File: rtl/smp_reg_init_seq.sv
module smp_reg_init_seq
  import smp_init_pkg::*;
#(
  parameter int          CFG_W     = 8,
  parameter int          WSR_W     = 8,
  parameter int          RSR_LEN   = 1024,
  parameter int          AW        = 4,
  parameter logic [3:0]  ADDR_IDLE = 4'b0000,
  parameter logic [3:0]  ADDR_CFG  = 4'b1100,
  parameter logic [3:0]  ADDR_WSR  = 4'b1101,
  parameter logic [3:0]  ADDR_RSR  = 4'b1011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_val_i,
  input  logic [WSR_W-1:0] wsr_val_i,
  output logic [AW-1:0]    addr_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             done_o
);
  localparam int MAX_A   = (CFG_W > WSR_W) ? CFG_W : WSR_W;
  localparam int MAX_LEN = (MAX_A > RSR_LEN) ? MAX_A : RSR_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seg_e             seg;
  logic [CNT_W-1:0] idx;
  logic             load, bit_end, run;

  assign run = (seg == SEG_CFG) || (seg == SEG_WSR) || (seg == SEG_RSR);

  smp_bit_phaser u_phaser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .sclk_o    (sclk_o),
    .bit_end_o (bit_end)
  );

  smp_seg_ctrl #(
    .CFG_W(CFG_W), .WSR_W(WSR_W), .RSR_LEN(RSR_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bit_end_i (bit_end),
    .seg_o     (seg),
    .idx_o     (idx),
    .load_o    (load),
    .done_o    (done_o)
  );

  smp_word_serializer #(
    .CFG_W(CFG_W), .WSR_W(WSR_W), .RSR_LEN(RSR_LEN), .CNT_W(CNT_W)
  ) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .cfg_val_i (cfg_val_i),
    .wsr_val_i (wsr_val_i),
    .seg_i     (seg),
    .idx_i     (idx),
    .sdata_o   (sdata_o)
  );

  always_comb begin
    unique case (seg)
      SEG_CFG: addr_o = AW'(ADDR_CFG);
      SEG_WSR: addr_o = AW'(ADDR_WSR);
      SEG_RSR: addr_o = AW'(ADDR_RSR);
      default: addr_o = AW'(ADDR_IDLE);
    endcase
  end

  p_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdata_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdata_o));
  p_addr_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(addr_o) && addr_o != AW'(ADDR_IDLE)));
  p_addr_change_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> !sclk_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (addr_o == AW'(ADDR_IDLE) && !sclk_o));
endmodule

// File: tb/smp_reg_init_seq_test.sv
module smp_reg_init_seq_test;
  localparam int CW = 8;
  localparam int WW = 8;
  localparam int RL = 32;
  localparam logic [3:0] A_IDLE = 4'b0000;
  localparam logic [3:0] A_CFG  = 4'b1100;
  localparam logic [3:0] A_WSR  = 4'b1101;
  localparam logic [3:0] A_RSR  = 4'b1011;
  localparam int LAT = 3 * (CW + WW + RL) + 3;

  typedef struct {
    logic [3:0]  code;
    int          nbits;
    logic [63:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] cfg_val_i = '0;
  logic [WW-1:0] wsr_val_i = '0;
  logic [3:0] addr_o;
  logic sclk_o, sdata_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  item_t exp_q[$];

  logic [CW-1:0] chip_cfg;
  logic [WW-1:0] chip_wsr;
  logic [RL-1:0] chip_rsr;

  always #10ns clk = ~clk;

  smp_reg_init_seq #(.CFG_W(CW), .WSR_W(WW), .RSR_LEN(RL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cfg_val_i(cfg_val_i), .wsr_val_i(wsr_val_i),
    .addr_o(addr_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor + chip model
  logic        p_sclk, p_sdata, p_done;
  logic [3:0]  p_addr;
  logic [63:0] cur_val;
  int          cur_n, idle_run;
  initial begin
    p_sclk = 0; p_sdata = 0; p_done = 0; p_addr = A_IDLE;
    cur_val = '0; cur_n = 0; idle_run = 0;
    chip_cfg = '1; chip_wsr = '1; chip_rsr = '1;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (sclk_o && !p_sclk) begin
        chk(sdata_o == p_sdata, "R6 setup", sdata_o, p_sdata);
        chk(addr_o != A_IDLE, "R7 addr at clk", addr_o, 0);
        cur_val = {cur_val[62:0], sdata_o};
        cur_n++;
        if (addr_o == A_CFG) chip_cfg = {chip_cfg[CW-2:0], sdata_o};
        if (addr_o == A_WSR) chip_wsr = {chip_wsr[WW-2:0], sdata_o};
        if (addr_o == A_RSR) chip_rsr = {chip_rsr[RL-2:0], sdata_o};
      end
      if (sclk_o && p_sclk) chk(0, "R6 clk high one cycle", 1, 0);
      if (!sclk_o && p_sclk) chk(sdata_o == p_sdata, "R6 hold", sdata_o, p_sdata);
      if (addr_o != p_addr) begin
        chk(!sclk_o && !p_sclk, "R7 change with clk low", sclk_o, 0);
        chk(p_addr == A_IDLE || addr_o == A_IDLE, "R7 direct code change", addr_o, A_IDLE);
      end
      if (addr_o != A_IDLE && p_addr == A_IDLE && addr_o != A_CFG)
        chk(idle_run == 1, "R5 gap length", idle_run, 1);
      if (addr_o == A_IDLE && p_addr != A_IDLE) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected segment", p_addr, 0);
        else begin
          item_t it;
          string rq;
          it = exp_q.pop_front();
          rq = (it.code == A_CFG) ? "R2" : (it.code == A_WSR) ? "R3" : "R4";
          chk(p_addr == it.code, {rq, " R5 code/order"}, p_addr, it.code);
          chk(cur_n == it.nbits, {rq, " bit count"}, cur_n, it.nbits);
          chk(cur_val == it.val, {rq, " value"}, cur_val, it.val);
        end
        cur_val = '0; cur_n = 0;
      end
      idle_run = (addr_o == A_IDLE) ? idle_run + 1 : 0;
      if (done_o) begin
        chk(!p_done, "R8 single pulse", p_done, 0);
        chk(addr_o == A_IDLE && !sclk_o, "R8 idle at done", addr_o, A_IDLE);
      end
      p_sclk = sclk_o; p_sdata = sdata_o; p_addr = addr_o; p_done = done_o;
    end
  end

  task automatic run_seq(input logic [CW-1:0] c, input logic [WW-1:0] w,
                         input bit busy_starts, input bit wiggle);
    item_t it;
    int n;
    it.code = A_CFG; it.nbits = CW; it.val = 64'(c); exp_q.push_back(it);
    it.code = A_WSR; it.nbits = WW; it.val = 64'(w); exp_q.push_back(it);
    it.code = A_RSR; it.nbits = RL; it.val = 64'd1; exp_q.push_back(it);
    @(negedge clk);
    cfg_val_i = c; wsr_val_i = w; start_i = 1'b1;
    n = 0;
    while (n < LAT + 20) begin
      @(negedge clk);
      n++;
      start_i = busy_starts && (n == 5 || n == 40 || n == 140);
      if (wiggle) begin cfg_val_i = ~c; wsr_val_i = ~w; end
      if (done_o) break;
    end
    start_i = 1'b0;
    chk(n == LAT, "R8 latency", n, LAT);
    chk(chip_cfg == c, "R2 R10 chip cfg", chip_cfg, c);
    chk(chip_wsr == w, "R3 R10 chip wsr", chip_wsr, w);
    chk(chip_rsr == RL'(1), "R4 chip ring marker", chip_rsr, 1);
    repeat (10) @(negedge clk);
    chk(addr_o == A_IDLE && !sclk_o, "R9 no restart", addr_o, A_IDLE);
    chk(exp_q.size() == 0, "R5 all segments seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_o == A_IDLE, "R1 addr", addr_o, A_IDLE);
    chk(!sclk_o, "R1 sclk", sclk_o, 0);
    chk(!sdata_o, "R1 sdata", sdata_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(8'hFF, 8'hFF, 0, 0);
    run_seq(8'hA5, 8'h3C, 0, 0);
    run_seq(8'h01, 8'h80, 1, 0);   // R9
    run_seq(8'h5A, 8'hC3, 0, 1);   // R10
    run_seq(8'h00, 8'h7E, 1, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule